// File: doc/BRIEF.md
# Voltage Domain Power State Controller

This block sets the power state of a single voltage domain, for example one cryptographic engine. Software asks for a target level: Full (1.8 V), Low (1.5 V), Ultralow (1.2 V) or Sleep (0 V). For a supply level the controller drives a voltage-select code to an external voltage generator. For Sleep it drives a clamp enable that gates the domain supply off. After each change of supply level it waits for that transition's settling delay before it reports the domain ready again.

The controller runs from a 60 MHz clock and holds each delay in microseconds as a parameter. It converts each delay to cycles at 60 cycles per microsecond. The state machine has two states. READY accepts requests. SETTLE waits for the settling timer. Each accepted level change takes the transition READY->SETTLE, and expiry of the timer takes SETTLE->READY. A request for the current level, and entry into Sleep, stay in READY.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: After reset the controller is in READY with `cur_level` = 2'b11 (Full), `vsel` = 2'b11, `clamp_en` = 0, `ready` = 1 and `req_err` = 0.
- R2: Level codes are 2'b00 Sleep, 2'b01 Ultralow (1.2 V), 2'b10 Low (1.5 V) and 2'b11 Full (1.8 V). `vsel` uses the same code for the voltage. An accepted change to a supply level drives `vsel` to the target on the accepting clock edge.
- R3: Each upward scaling drops `ready` for exactly this many cycles after the accepting edge: Ultralow->Low 600, Ultralow->Full 1800, Low->Full 960. `cur_level` keeps the old level until `ready` returns.
- R4: Each downward scaling drops `ready` for exactly this many cycles: Full->Low 480, Full->Ultralow 720, Low->Ultralow 300.
- R5: Each wake from Sleep drops `ready` for exactly this many cycles: to Ultralow 1200, to Low 2100, to Full 3780. `clamp_en` is released on the accepting edge.
- R6: A Sleep request in READY asserts `clamp_en` and sets `cur_level` to Sleep on the accepting edge. It leaves `vsel` unchanged and keeps `ready` high.
- R7: A request for the current level changes no output, and `ready` stays high.
- R8: A request made while `ready` is low is ignored. `req_err` is high for exactly the one cycle that follows it. The settling time and the final level of the transition in progress do not change.
- R9: `req_err` stays low after any request accepted in READY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Level request strobe, one cycle |
| req_level | input | 2 | Requested level code |
| ready | output | 1 | Domain settled, requests accepted |
| cur_level | output | 2 | Settled level code |
| vsel | output | 2 | Voltage-select code to the generator |
| clamp_en | output | 1 | Supply clamp enable (Sleep) |
| req_err | output | 1 | Pulse: request dropped while busy |

## Verification
The bench walks all nine supply transitions and all three Sleep entries, and counts exactly how many cycles `ready` stays low. A wrong table entry or a counter that is off by one cycle changes that count. A design that rescales the voltage on Sleep entry, or that keeps the clamp on while waking, shows up in `vsel` and `clamp_en`. A request is also injected in the middle of a settle. A design that accepted it would change the target or restart the timer, and one that did not flag it would leave `req_err` low. A request for the current level must not drop `ready`.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    typedef enum logic [1:0] {
        LVL_SLEEP = 2'b00,
        LVL_ULOW  = 2'b01,
        LVL_LOW   = 2'b10,
        LVL_FULL  = 2'b11
    } lvl_e;

    typedef enum logic {
        ST_READY  = 1'b0,
        ST_SETTLE = 1'b1
    } st_e;
endpackage

// File: rtl/pdc_delay_lut.sv
module pdc_delay_lut
    import pdc_pkg::*;
#(
    parameter int CYC_PER_US = 60,
    parameter int CNT_W      = 12,
    parameter int US_S_U     = 20,
    parameter int US_S_L     = 35,
    parameter int US_S_F     = 63,
    parameter int US_U_L     = 10,
    parameter int US_U_F     = 30,
    parameter int US_L_F     = 16,
    parameter int US_F_L     = 8,
    parameter int US_F_U     = 12,
    parameter int US_L_U     = 5
) (
    input  lvl_e             from_lvl,
    input  lvl_e             to_lvl,
    output logic [CNT_W-1:0] load_val
);
    int us;
    int cyc;

    always_comb begin
        us = 0;
        unique case ({from_lvl, to_lvl})
            {LVL_SLEEP, LVL_ULOW}: us = US_S_U;
            {LVL_SLEEP, LVL_LOW }: us = US_S_L;
            {LVL_SLEEP, LVL_FULL}: us = US_S_F;
            {LVL_ULOW,  LVL_LOW }: us = US_U_L;
            {LVL_ULOW,  LVL_FULL}: us = US_U_F;
            {LVL_LOW,   LVL_FULL}: us = US_L_F;
            {LVL_FULL,  LVL_LOW }: us = US_F_L;
            {LVL_FULL,  LVL_ULOW}: us = US_F_U;
            {LVL_LOW,   LVL_ULOW}: us = US_L_U;
            default:               us = 0;
        endcase
        cyc      = us * CYC_PER_US;
        load_val = (cyc == 0) ? '0 : CNT_W'(cyc - 1);
    end
endmodule

// File: rtl/pdc_settle_timer.sv
module pdc_settle_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R3 R4 R5: the timer counts down one step per cycle
    a_r3_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));

    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
    import pdc_pkg::*;
#(
    parameter int CYC_PER_US = 60,
    parameter int US_S_U     = 20,
    parameter int US_S_L     = 35,
    parameter int US_S_F     = 63,
    parameter int US_U_L     = 10,
    parameter int US_U_F     = 30,
    parameter int US_L_F     = 16,
    parameter int US_F_L     = 8,
    parameter int US_F_U     = 12,
    parameter int US_L_U     = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_level,
    output logic       ready,
    output logic [1:0] cur_level,
    output logic [1:0] vsel,
    output logic       clamp_en,
    output logic       req_err
);
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int MAX_US  = max_of(max_of(max_of(US_S_U, US_S_L), max_of(US_S_F, US_U_L)),
                                    max_of(max_of(US_U_F, US_L_F), max_of(max_of(US_F_L, US_F_U), US_L_U)));
    localparam int MAX_CYC = MAX_US * CYC_PER_US;
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    st_e              state;
    lvl_e             cur_q, tgt_q, vsel_q;
    lvl_e             req_lvl;
    logic             clamp_q, err_q;
    logic             move, t_zero;
    logic [CNT_W-1:0] t_load_val;

    assign req_lvl = lvl_e'(req_level);
    assign move    = (state == ST_READY) && req_valid && (req_lvl != cur_q) && (req_lvl != LVL_SLEEP);

    pdc_delay_lut #(
        .CYC_PER_US(CYC_PER_US), .CNT_W(CNT_W),
        .US_S_U(US_S_U), .US_S_L(US_S_L), .US_S_F(US_S_F),
        .US_U_L(US_U_L), .US_U_F(US_U_F), .US_L_F(US_L_F),
        .US_F_L(US_F_L), .US_F_U(US_F_U), .US_L_U(US_L_U)
    ) u_lut (
        .from_lvl (cur_q),
        .to_lvl   (req_lvl),
        .load_val (t_load_val)
    );

    pdc_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (move),
        .load_val (t_load_val),
        .zero     (t_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_READY;
            cur_q   <= LVL_FULL;
            tgt_q   <= LVL_FULL;
            vsel_q  <= LVL_FULL;
            clamp_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= req_valid && (state == ST_SETTLE);
            unique case (state)
                ST_READY: begin
                    if (req_valid && req_lvl != cur_q) begin
                        if (req_lvl == LVL_SLEEP) begin
                            clamp_q <= 1'b1;
                            cur_q   <= LVL_SLEEP;
                        end else begin
                            tgt_q   <= req_lvl;
                            vsel_q  <= req_lvl;
                            clamp_q <= 1'b0;
                            state   <= ST_SETTLE;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (t_zero) begin
                        cur_q <= tgt_q;
                        state <= ST_READY;
                    end
                end
                default: state <= ST_READY;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready     = (state == ST_READY);
        cur_level = cur_q;
        vsel      = vsel_q;
        clamp_en  = clamp_q;
        req_err   = err_q;
    end

    a_r2_move_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && req_level != cur_level && req_level != 2'b00)
            |=> (!ready && vsel == $past(req_level)));

    a_r6_sleep_keeps_vsel: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && req_level == 2'b00)
            |=> (ready && clamp_en && $stable(vsel)));

    a_r6_clamp_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_en |-> (ready && cur_level == 2'b00));

    a_r7_same_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && req_level == cur_level)
            |=> (ready && $stable(cur_level) && $stable(vsel) && $stable(clamp_en)));

    a_r8_busy_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && req_valid) |=> (req_err && $stable(vsel)));

    a_r9_no_err_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !req_err);
endmodule

// File: tb/pwr_domain_ctrl_test.sv
module pwr_domain_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_level = 2'b00;
    logic       ready, clamp_en, req_err;
    logic [1:0] cur_level, vsel;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    pwr_domain_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .ready(ready), .cur_level(cur_level), .vsel(vsel),
        .clamp_en(clamp_en), .req_err(req_err)
    );

    // {level[13:12], expected low cycles[11:0]}
    localparam int NV = 13;
    localparam logic [13:0] VEC [NV] = '{
        {2'b10, 12'd480},  {2'b01, 12'd300},  {2'b11, 12'd1800},
        {2'b01, 12'd720},  {2'b10, 12'd600},  {2'b11, 12'd960},
        {2'b00, 12'd0},    {2'b01, 12'd1200}, {2'b00, 12'd0},
        {2'b10, 12'd2100}, {2'b00, 12'd0},    {2'b11, 12'd3780},
        {2'b11, 12'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string tag(input logic [1:0] from, input logic [1:0] to);
        if (to == from)       return "R7";
        if (to == 2'b00)      return "R6";
        if (from == 2'b00)    return "R5";
        if (to > from)        return "R3";
        return "R4";
    endfunction

    // issue a request; returns low-cycle count and first-cycle observations
    task automatic do_req(input logic [1:0] lvl, output int lows,
                          output logic [1:0] v0, output logic c0, output logic e0,
                          output logic [1:0] cl0);
        @(negedge clk);
        req_valid = 1'b1;
        req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
        v0 = vsel; c0 = clamp_en; e0 = req_err; cl0 = cur_level;
        lows = 0;
        while (!ready && lows < 10000) begin
            lows++;
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev, pv, v0, cl0, lv;
        logic       c0, e0;
        int         lows, exp;
        string      t;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", ready, 1);
        check("R1 cur_level", cur_level, 2'b11);
        check("R1 vsel", vsel, 2'b11);
        check("R1 clamp_en", clamp_en, 0);
        check("R1 req_err", req_err, 0);

        prev = 2'b11;
        pv   = 2'b11;
        for (int i = 0; i < NV; i++) begin
            lv  = VEC[i][13:12];
            exp = int'(VEC[i][11:0]);
            t   = tag(prev, lv);
            do_req(lv, lows, v0, c0, e0, cl0);
            check({t, " settle cycles"}, lows, exp);
            check({t, " cur_level"}, cur_level, lv);
            check("R9 req_err", e0, 0);
            if (lv == 2'b00) begin
                check("R6 vsel unchanged", v0, pv);
                check("R6 clamp on", c0, 1);
            end else if (lv == prev) begin
                check("R7 vsel unchanged", v0, pv);
                check("R7 clamp", c0, prev == 2'b00);
            end else begin
                check("R2 vsel on accept", v0, lv);
                check({t, " old level while settling"}, cl0, prev);
                check("R5 clamp released", c0, 0);
                pv = lv;
            end
            check({t, " final vsel"}, vsel, pv);
            check({t, " final clamp"}, clamp_en, lv == 2'b00);
            prev = lv;
        end

        // R8: request while settling Full->Ultralow (720 cycles)
        @(negedge clk);
        req_valid = 1'b1; req_level = 2'b01;
        @(negedge clk);
        req_valid = 1'b0;
        lows = 0;
        while (!ready && lows < 10000) begin
            lows++;
            if (lows == 100) begin
                req_valid = 1'b1; req_level = 2'b10;
            end
            if (lows == 101) begin
                req_valid = 1'b0;
                check("R8 req_err pulse", req_err, 1);
                check("R8 vsel kept", vsel, 2'b01);
            end
            if (lows == 102) check("R8 req_err one cycle", req_err, 0);
            @(negedge clk);
        end
        check("R8 settle time unchanged", lows, 720);
        check("R8 final level", cur_level, 2'b01);
        check("R8 vsel final", vsel, 2'b01);

        // R7: same level once more, ready never drops
        do_req(2'b01, lows, v0, c0, e0, cl0);
        check("R7 no settle", lows, 0);
        check("R7 level kept", cur_level, 2'b01);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule